// File: doc/BRIEF.md
# Packet Byte Tally with Termination Status

This block sits between a streaming sink and the write side of a stream-to-memory DMA engine. Once a transfer is armed with a byte budget, it accepts stream beats, counts the bytes of one packet from its start-of-packet beat up to and including its end-of-packet beat, and ORs together the error code bits that arrive with those beats. Beats seen before the packet starts are discarded. When the packet closes, or when the budget is used up first, it offers a byte count and a 16-bit status word on a valid/ready response port.

Bit 8 of the status word reports that the budget ran out before the end-of-packet beat arrived. Bits 7:0 hold the accumulated stream error code. A start input arms each transfer and also picks the mode. In packet mode the counting described above applies. In plain mode the block only meters beats against the budget, and the count it reports is zero.

Top module: `pkt_byte_tally`

## Requirements
- R1: After reset, `r_valid` and `s_ready` are both 0.
- R2: When `start` is high while the block is idle, the block latches `budget`, `pkt_mode` and `err_en`, clears its count and error state, and raises `s_ready` on the next cycle.
- R3: In packet mode, a beat accepted before the first beat with `s_sop`=1 is dropped. It adds no bytes and contributes no error bits.
- R4: In packet mode, the reported count is the sum of bytes over the beats from the SOP beat through the EOP beat. Each non-final beat adds DATA_BYTES. The EOP beat adds DATA_BYTES minus `s_empty`.
- R5: When the EOP beat is accepted, `r_valid` is high in the following cycle and status bit 8 is 0. This holds even if the same beat also reaches the budget.
- R6: In packet mode, if a counted beat without EOP brings the byte total to a value at least `budget`, the transfer ends. `r_valid` is high the next cycle, status bit 8 is 1, and the count equals the bytes accepted. A budget of 0 ends the transfer on the first counted beat.
- R7: Status bits 7:0 are the OR of `s_error` over all counted beats when `err_en` was latched high. They are 0 when `err_en` was latched low.
- R8: Status bits 15:9 are always 0.
- R9: While `r_valid` is high and `r_ready` is low, `r_valid`, `r_count` and `r_status` hold steady and `s_ready` is 0. The cycle after `r_ready` is seen high, `r_valid` is 0.
- R10: In plain mode (`pkt_mode` latched 0), `s_sop`, `s_eop` and `s_empty` are ignored. Every beat adds DATA_BYTES toward the budget, the transfer ends when the budget is reached, `r_count` is 0 and status bit 8 is 0.
- R11: A `start` pulse while a transfer is running or a response is pending is ignored. The running transfer keeps its original budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Arms a new transfer when idle |
| budget | input | CNT_W | Byte budget for the transfer being armed |
| pkt_mode | input | 1 | 1 = packet counting, 0 = plain metering |
| err_en | input | 1 | 1 = capture stream error bits |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Block accepts beats (transfer running) |
| s_sop | input | 1 | Beat starts a packet |
| s_eop | input | 1 | Beat ends a packet |
| s_empty | input | $clog2(DATA_BYTES) | Unused bytes in the EOP beat |
| s_error | input | ERR_W | Error code carried with the beat |
| r_valid | output | 1 | Response available |
| r_ready | input | 1 | Response consumed |
| r_count | output | CNT_W | Bytes counted for the packet |
| r_status | output | 16 | {7'b0, early-termination, error bits} |

## Verification
A beat accepted on a rising edge affects the response state on that same edge. So `r_valid`, `r_count` and `r_status` are due one cycle after the final beat is driven. A `start` raises `s_ready` one cycle later, and a response handshake drops `r_valid` one cycle later. The bench drives every input on the falling edge and samples on the next falling edge, half a period after the edge that made the change. Packet lengths, empty values, budgets and leading junk beats are swept. The expected count and status for each case are computed arithmetically from the beat pattern.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
    localparam int STATUS_W = 16;
    localparam int ET_BIT   = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RESP = 2'd2
    } pbt_state_e;
endpackage

// File: rtl/pbt_beat_bytes.sv
module pbt_beat_bytes #(
    parameter int DATA_BYTES = 4,
    parameter int CNT_W      = 16,
    localparam int EMPTY_W   = $clog2(DATA_BYTES)
) (
    input  logic [EMPTY_W-1:0] empty,
    output logic [CNT_W-1:0]   last_bytes
);
    // bytes carried by a final (EOP) beat
    always_comb begin
        last_bytes = CNT_W'(DATA_BYTES) - CNT_W'(empty);
    end
endmodule

// File: rtl/pbt_ctrl.sv
module pbt_ctrl
    import pbt_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int CNT_W      = 16,
    parameter int ERR_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CNT_W-1:0]    budget,
    input  logic                pkt_mode,
    input  logic                err_en,
    input  logic                s_valid,
    input  logic                s_sop,
    input  logic                s_eop,
    input  logic [ERR_W-1:0]    s_error,
    input  logic [CNT_W-1:0]    last_bytes,
    output logic                s_ready,
    output logic                r_valid,
    input  logic                r_ready,
    output logic [CNT_W-1:0]    r_count,
    output logic [STATUS_W-1:0] r_status
);
    typedef struct packed {
        pbt_state_e       st;
        logic [CNT_W:0]   cnt;
        logic [CNT_W-1:0] bud;
        logic [ERR_W-1:0] err;
        logic             in_pkt;
        logic             pkt;
        logic             err_en;
        logic             et;
    } ctrl_t;

    ctrl_t q, d;

    logic           accept;
    logic           counted;
    logic [CNT_W:0] beat_bytes;
    logic [CNT_W:0] sum;

    always_comb begin
        d          = q;
        accept     = s_valid && (q.st == ST_RUN);
        counted    = !q.pkt || q.in_pkt || s_sop;
        beat_bytes = (q.pkt && s_eop) ? {1'b0, last_bytes} : (CNT_W+1)'(DATA_BYTES);
        sum        = q.cnt + beat_bytes;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st     = ST_RUN;
                    d.cnt    = '0;
                    d.bud    = budget;
                    d.err    = '0;
                    d.in_pkt = 1'b0;
                    d.pkt    = pkt_mode;
                    d.err_en = err_en;
                    d.et     = 1'b0;
                end
            end
            ST_RUN: begin
                if (accept && counted) begin
                    d.cnt    = sum;
                    d.in_pkt = 1'b1;
                    if (q.err_en) d.err = q.err | s_error;
                    if (q.pkt && s_eop) begin
                        d.st = ST_RESP;
                        d.et = 1'b0;
                    end else if (sum >= {1'b0, q.bud}) begin
                        d.st = ST_RESP;
                        d.et = q.pkt;
                    end
                end
            end
            ST_RESP: begin
                if (r_ready) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        s_ready  = (q.st == ST_RUN);
        r_valid  = (q.st == ST_RESP);
        r_count  = q.pkt ? q.cnt[CNT_W-1:0] : '0;
        r_status = '0;
        r_status[ERR_W-1:0] = q.err;
        r_status[ET_BIT]    = q.et;
    end

    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> (r_status[STATUS_W-1:ET_BIT+1] == '0)); // R8
    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_count) && $stable(r_status))); // R9
    AST_RESP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_ready) |=> !r_valid); // R9
    AST_NO_SINK_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> !s_ready); // R9
    AST_ET_OVER_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_status[ET_BIT]) |-> (q.cnt >= {1'b0, q.bud})); // R6
    AST_PLAIN_NO_ET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !q.pkt) |-> (!r_status[ET_BIT] && r_count == '0)); // R10
    AST_BUDGET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && $past(s_ready)) |-> $stable(q.bud)); // R11
endmodule

// File: rtl/pkt_byte_tally.sv
module pkt_byte_tally
    import pbt_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int CNT_W      = 16,
    parameter int ERR_W      = 8,
    localparam int EMPTY_W   = $clog2(DATA_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CNT_W-1:0]    budget,
    input  logic                pkt_mode,
    input  logic                err_en,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic                s_sop,
    input  logic                s_eop,
    input  logic [EMPTY_W-1:0]  s_empty,
    input  logic [ERR_W-1:0]    s_error,
    output logic                r_valid,
    input  logic                r_ready,
    output logic [CNT_W-1:0]    r_count,
    output logic [STATUS_W-1:0] r_status
);
    logic [CNT_W-1:0] last_bytes;

    pbt_beat_bytes #(.DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)) sizer_i (
        .empty      (s_empty),
        .last_bytes (last_bytes)
    );

    pbt_ctrl #(.DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W), .ERR_W(ERR_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .budget     (budget),
        .pkt_mode   (pkt_mode),
        .err_en     (err_en),
        .s_valid    (s_valid),
        .s_sop      (s_sop),
        .s_eop      (s_eop),
        .s_error    (s_error),
        .last_bytes (last_bytes),
        .s_ready    (s_ready),
        .r_valid    (r_valid),
        .r_ready    (r_ready),
        .r_count    (r_count),
        .r_status   (r_status)
    );
endmodule

// File: tb/pkt_byte_tally_tb_top.sv
module pkt_byte_tally_tb_top;
    localparam int DB = 4;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] budget = '0;
    logic pkt_mode = 1'b0, err_en = 1'b0;
    logic s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0;
    logic [1:0] s_empty = '0;
    logic [7:0] s_error = '0;
    logic r_ready = 1'b0;
    logic s_ready, r_valid;
    logic [CW-1:0] r_count;
    logic [15:0] r_status;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    pkt_byte_tally #(.DATA_BYTES(DB), .CNT_W(CW), .ERR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .budget(budget),
        .pkt_mode(pkt_mode), .err_en(err_en), .s_valid(s_valid), .s_ready(s_ready),
        .s_sop(s_sop), .s_eop(s_eop), .s_empty(s_empty), .s_error(s_error),
        .r_valid(r_valid), .r_ready(r_ready), .r_count(r_count), .r_status(r_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic arm(input int b, input logic pm, input logic ee);
        @(negedge clk);
        start = 1'b1; budget = CW'(b); pkt_mode = pm; err_en = ee;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic beat(input logic sop, input logic eop, input int emp, input logic [7:0] err);
        s_valid = 1'b1; s_sop = sop; s_eop = eop; s_empty = 2'(emp); s_error = err;
        @(negedge clk);
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; s_empty = '0; s_error = '0;
    endtask

    task automatic take(input string tag, input int cnt, input int st);
        chk({tag, " r_valid"}, 32'(r_valid), 32'd1);
        chk({tag, " r_count"}, 32'(r_count), 32'(cnt));
        chk({tag, " r_status"}, 32'(r_status), 32'(st));
        r_ready = 1'b1;
        @(negedge clk);
        r_ready = 1'b0;
        chk({tag, " R9 drop"}, 32'(r_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 r_valid", 32'(r_valid), 32'd0);
        chk("R1 s_ready", 32'(s_ready), 32'd0);
        rst_n = 1'b1;

        // R2: arm raises s_ready
        arm(1000, 1'b1, 1'b1);
        chk("R2 s_ready", 32'(s_ready), 32'd1);
        beat(1'b1, 1'b1, 0, 8'h00);
        take("R2 R5 single", 4, 0);

        // R3 R4 R5: sweep junk beats, packet length, empty
        for (int npre = 0; npre < 2; npre++)
            for (int n = 1; n <= 4; n++)
                for (int e = 0; e < 4; e++) begin
                    arm(1000, 1'b1, 1'b1);
                    for (int p = 0; p < npre; p++) beat(1'b0, 1'b0, 0, 8'h80);
                    for (int k = 1; k <= n; k++) beat(k == 1, k == n, (k == n) ? e : 0, 8'h00);
                    chk("R3 R4 s_ready low", 32'(s_ready), 32'd0);
                    take("R3 R4 R5 sweep", DB*(n-1) + (DB-e), 0);
                end

        // R6 and R10: budget sweep without EOP
        for (int pm = 0; pm < 2; pm++)
            for (int b = 0; b <= 12; b++) begin
                int kexp;
                int ksent;
                kexp = (b == 0) ? 1 : (b + DB - 1) / DB;
                ksent = 0;
                arm(b, pm[0], 1'b0);
                while (!r_valid && ksent < 6) begin
                    beat(ksent == 0, 1'b0, 3, 8'h00);
                    ksent++;
                end
                chk(pm ? "R6 beats" : "R10 beats", 32'(ksent), 32'(kexp));
                if (pm == 1) take("R6 budget", DB*kexp, 32'h100);
                else         take("R10 plain", 0, 0);
            end

        // R5: EOP on the beat that meets the budget
        arm(8, 1'b1, 1'b0);
        beat(1'b1, 1'b0, 0, 8'h00);
        beat(1'b0, 1'b1, 0, 8'h00);
        take("R5 eop wins", 8, 0);

        // R7: error accumulation on, then off
        arm(1000, 1'b1, 1'b1);
        beat(1'b0, 1'b0, 0, 8'h40);
        beat(1'b1, 1'b0, 0, 8'h01);
        beat(1'b0, 1'b0, 0, 8'h10);
        beat(1'b0, 1'b1, 1, 8'h02);
        take("R7 R3 err or", 11, 32'h13);
        arm(1000, 1'b1, 1'b0);
        beat(1'b1, 1'b1, 2, 8'hFF);
        take("R7 err off", 2, 0);

        // R8 with ET plus errors
        arm(5, 1'b1, 1'b1);
        beat(1'b1, 1'b0, 0, 8'hAA);
        beat(1'b0, 1'b0, 0, 8'h55);
        take("R8 R6 et+err", 8, 32'h1FF);

        // R9: hold while not ready
        arm(1000, 1'b1, 1'b1);
        beat(1'b1, 1'b1, 3, 8'h07);
        repeat (3) @(negedge clk);
        chk("R9 hold valid", 32'(r_valid), 32'd1);
        chk("R9 hold s_ready", 32'(s_ready), 32'd0);
        take("R9 held", 1, 32'h07);

        // R11: start while running is ignored
        arm(4, 1'b1, 1'b0);
        @(negedge clk);
        start = 1'b1; budget = 16'd100;
        @(negedge clk);
        start = 1'b0;
        beat(1'b1, 1'b0, 0, 8'h00);
        take("R11 budget kept", 4, 32'h100);
        chk("R11 idle after", 32'(s_ready), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule